// File: doc/BRIEF.md
# Multi-Thread Transfer Pointer Manager

This block holds the memory pointers that a host adapter uses to move command, data and status bytes for several I/O threads that can be suspended and resumed on one shared bus. One live set of three pointers belongs to whichever thread is connected at the moment. Each thread also has a stored set, which is the only copy that lasts across a disconnect.

A thread is opened with its three block start addresses. Reconnecting a thread by its index loads the live set from that thread's stored set. While the thread is connected, per-byte strobes advance the live pointers. A save message copies the live data pointer into the stored set. A restore message loads the live set from the stored set. Disconnecting discards the live values. Command completion closes the thread and raises a one-cycle interrupt that carries the thread index.

The control is a two-state machine. `LNK_IDLE` means no thread is connected. `LNK_HELD` means one thread is connected. The transitions are:
- LNK_IDLE to LNK_HELD on a reconnect to an active thread.
- LNK_HELD to LNK_IDLE on a disconnect.
- LNK_HELD to LNK_IDLE on a completion.

Every other input leaves the state unchanged.

Top module: `xfer_ptr_keeper`

## Requirements
- R1: After reset the block is in LNK_IDLE. `linked`, all three current pointers, `irq`, `err_reopen` and `err_proto` are zero.
- R2: With `open_vld` high, an inactive thread `open_tid` becomes active. Its stored command, data and status pointers are set to the three given start addresses. Opening a thread that is already active changes nothing, and `err_reopen` is high in the next cycle.
- R3: In LNK_IDLE, a reconnect to an active thread gives the following in the next cycle: `linked`=1, `link_tid` equal to that thread, and the current set equal to that thread's stored set. A reconnect to an inactive thread, or any reconnect while in LNK_HELD, is ignored and pulses `err_proto` in the next cycle.
- R4: In LNK_HELD, each advance strobe raises its own current pointer by exactly one per cycle. All three strobes may be high together. In LNK_IDLE the strobes have no effect.
- R5: A save in LNK_HELD copies the current data pointer, as it was before that cycle's advance, into the connected thread's stored data pointer. The stored command and status pointers never change after open.
- R6: A restore in LNK_HELD loads all three stored values of the connected thread into the current set. A save and any advances in the same cycle are dropped.
- R7: A disconnect in LNK_HELD returns to LNK_IDLE with all current pointers reading zero. The thread's stored set is kept, so a later reconnect resumes from it.
- R8: A completion in LNK_HELD returns to LNK_IDLE and deactivates the thread. It also pulses `irq` for one cycle with `irq_tid` equal to the thread index. Afterwards the thread may be reopened, and a reconnect to it is rejected.
- R9: A save or restore while in LNK_IDLE is ignored, and `err_proto` pulses in the next cycle.
- R10: In LNK_HELD the same-cycle priority is completion, then disconnect, then restore, then save. Completion and disconnect in LNK_IDLE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_vld | input | 1 | Open a thread |
| open_tid | input | TW | Thread index to open |
| open_cmd | input | PW | Command block start |
| open_dat | input | PW | Data block start |
| open_sts | input | PW | Status block start |
| adv_cmd | input | 1 | One command byte moved |
| adv_dat | input | 1 | One data byte moved |
| adv_sts | input | 1 | One status byte moved |
| save_dp | input | 1 | Save-data-pointer message |
| restore_all | input | 1 | Restore-pointers message |
| disc | input | 1 | Disconnect |
| reconn | input | 1 | Reconnect request |
| reconn_tid | input | TW | Reconnecting thread index |
| cmd_done | input | 1 | Command-complete message |
| linked | output | 1 | A thread is connected |
| link_tid | output | TW | Connected thread index |
| cur_cmd | output | PW | Current command pointer |
| cur_dat | output | PW | Current data pointer |
| cur_sts | output | PW | Current status pointer |
| irq | output | 1 | Completion pulse |
| irq_tid | output | TW | Thread that completed |
| err_reopen | output | 1 | Open of an active thread |
| err_proto | output | 1 | Message with no valid connection |

## Verification
Every result is registered, so each stimulus shows its effect exactly one clock after the edge that samples it. This covers pointer moves, loads and clears, state changes, the interrupt and both error pulses. The bench drives inputs just after a rising edge. A behavioural model updates on the next rising edge, and every output is compared with it on the falling edge that follows, where the one-cycle latency has already elapsed. The directed sequences place competing messages in one cycle to exercise the priority order. A long random phase then compares every cycle.

// File: rtl/xptr_pkg.sv
package xptr_pkg;
    typedef enum logic {
        LNK_IDLE = 1'b0,
        LNK_HELD = 1'b1
    } link_state_t;
endpackage

// File: rtl/xptr_saved_bank.sv
module xptr_saved_bank #(
    parameter int NT = 4,
    parameter int PW = 32,
    parameter int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_we,
    input  logic [TW-1:0] open_tid,
    input  logic [PW-1:0] open_cmd,
    input  logic [PW-1:0] open_dat,
    input  logic [PW-1:0] open_sts,
    input  logic          save_we,
    input  logic [TW-1:0] save_tid,
    input  logic [PW-1:0] save_val,
    input  logic          kill_we,
    input  logic [TW-1:0] kill_tid,
    input  logic [TW-1:0] rd_tid,
    output logic [PW-1:0] rd_cmd,
    output logic [PW-1:0] rd_dat,
    output logic [PW-1:0] rd_sts,
    output logic [NT-1:0] active
);
    logic [PW-1:0] st_cmd [NT];
    logic [PW-1:0] st_dat [NT];
    logic [PW-1:0] st_sts [NT];
    logic [NT-1:0] hit_open, hit_save, hit_kill;

    // per-thread write decode
    for (genvar g = 0; g < NT; g++) begin : g_dec
        assign hit_open[g] = open_we && (open_tid == TW'(g));
        assign hit_save[g] = save_we && (save_tid == TW'(g));
        assign hit_kill[g] = kill_we && (kill_tid == TW'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= '0;
            for (int i = 0; i < NT; i++) begin
                st_cmd[i] <= '0;
                st_dat[i] <= '0;
                st_sts[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (hit_open[i]) begin
                    active[i] <= 1'b1;
                    st_cmd[i] <= open_cmd;
                    st_dat[i] <= open_dat;
                    st_sts[i] <= open_sts;
                end else begin
                    if (hit_save[i]) st_dat[i] <= save_val;
                    if (hit_kill[i]) active[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_cmd = st_cmd[rd_tid];
    assign rd_dat = st_dat[rd_tid];
    assign rd_sts = st_sts[rd_tid];
endmodule

// File: rtl/xptr_live_set.sv
module xptr_live_set #(
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [PW-1:0] ld_cmd,
    input  logic [PW-1:0] ld_dat,
    input  logic [PW-1:0] ld_sts,
    input  logic [2:0]    inc,
    output logic [PW-1:0] cur_cmd,
    output logic [PW-1:0] cur_dat,
    output logic [PW-1:0] cur_sts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cmd <= '0;
            cur_dat <= '0;
            cur_sts <= '0;
        end else if (clr) begin
            cur_cmd <= '0;
            cur_dat <= '0;
            cur_sts <= '0;
        end else if (ld) begin
            cur_cmd <= ld_cmd;
            cur_dat <= ld_dat;
            cur_sts <= ld_sts;
        end else begin
            if (inc[0]) cur_cmd <= cur_cmd + PW'(1);
            if (inc[1]) cur_dat <= cur_dat + PW'(1);
            if (inc[2]) cur_sts <= cur_sts + PW'(1);
        end
    end
endmodule

// File: rtl/xfer_ptr_keeper.sv
module xfer_ptr_keeper #(
    parameter int NT = 4,
    parameter int PW = 32,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_vld,
    input  logic [TW-1:0] open_tid,
    input  logic [PW-1:0] open_cmd,
    input  logic [PW-1:0] open_dat,
    input  logic [PW-1:0] open_sts,
    input  logic          adv_cmd,
    input  logic          adv_dat,
    input  logic          adv_sts,
    input  logic          save_dp,
    input  logic          restore_all,
    input  logic          disc,
    input  logic          reconn,
    input  logic [TW-1:0] reconn_tid,
    input  logic          cmd_done,
    output logic          linked,
    output logic [TW-1:0] link_tid,
    output logic [PW-1:0] cur_cmd,
    output logic [PW-1:0] cur_dat,
    output logic [PW-1:0] cur_sts,
    output logic          irq,
    output logic [TW-1:0] irq_tid,
    output logic          err_reopen,
    output logic          err_proto
);
    import xptr_pkg::*;

    link_state_t   st_q, st_d;
    logic [NT-1:0] act;
    logic [TW-1:0] rd_tid;
    logic [PW-1:0] sv_cmd, sv_dat, sv_sts;
    logic          in_link, open_ok, reconn_ok;
    logic          finish, drop, reload, keep, save_ok;

    assign in_link   = (st_q == LNK_HELD);
    assign open_ok   = open_vld && !act[open_tid];
    assign reconn_ok = !in_link && reconn && act[reconn_tid];
    assign rd_tid    = in_link ? link_tid : reconn_tid;

    // message priority while connected: done > disc > restore > save
    assign finish  = in_link && cmd_done;
    assign drop    = in_link && !cmd_done && disc;
    assign reload  = in_link && !cmd_done && !disc && restore_all;
    assign keep    = in_link && !cmd_done && !disc && !restore_all;
    assign save_ok = keep && save_dp;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LNK_IDLE: if (reconn_ok)      st_d = LNK_HELD;
            LNK_HELD: if (finish || drop) st_d = LNK_IDLE;
            default:                      st_d = LNK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LNK_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_tid   <= '0;
            irq        <= 1'b0;
            irq_tid    <= '0;
            err_reopen <= 1'b0;
            err_proto  <= 1'b0;
        end else begin
            if (reconn_ok) link_tid <= reconn_tid;
            irq        <= finish;
            if (finish) irq_tid <= link_tid;
            err_reopen <= open_vld && act[open_tid];
            err_proto  <= in_link ? reconn
                        : (save_dp || restore_all || (reconn && !act[reconn_tid]));
        end
    end

    assign linked = in_link;

    xptr_saved_bank #(.NT(NT), .PW(PW), .TW(TW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_we  (open_ok),
        .open_tid (open_tid),
        .open_cmd (open_cmd),
        .open_dat (open_dat),
        .open_sts (open_sts),
        .save_we  (save_ok),
        .save_tid (link_tid),
        .save_val (cur_dat),
        .kill_we  (finish),
        .kill_tid (link_tid),
        .rd_tid   (rd_tid),
        .rd_cmd   (sv_cmd),
        .rd_dat   (sv_dat),
        .rd_sts   (sv_sts),
        .active   (act)
    );

    xptr_live_set #(.PW(PW)) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (finish || drop),
        .ld      (reconn_ok || reload),
        .ld_cmd  (sv_cmd),
        .ld_dat  (sv_dat),
        .ld_sts  (sv_sts),
        .inc     ({3{keep}} & {adv_sts, adv_dat, adv_cmd}),
        .cur_cmd (cur_cmd),
        .cur_dat (cur_dat),
        .cur_sts (cur_sts)
    );
endmodule

// File: rtl/xfer_ptr_keeper_chk.sv
module xfer_ptr_keeper_chk #(
    parameter int NT = 4,
    parameter int PW = 32,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adv_cmd,
    input logic          adv_dat,
    input logic          save_dp,
    input logic          restore_all,
    input logic          disc,
    input logic          cmd_done,
    input logic          linked,
    input logic [PW-1:0] cur_cmd,
    input logic [PW-1:0] cur_dat,
    input logic [PW-1:0] cur_sts,
    input logic          irq
);
    // R7: nothing connected means the live set reads zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !linked |-> (cur_cmd == '0 && cur_dat == '0 && cur_sts == '0));

    // R4: command pointer steps by one on an accepted strobe
    a_r4_cmd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && $past(linked && adv_cmd && !restore_all && !disc && !cmd_done))
        |-> cur_cmd == $past(cur_cmd) + PW'(1));

    // R4: data pointer steps by one on an accepted strobe
    a_r4_dat_step: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && $past(linked && adv_dat && !restore_all && !disc && !cmd_done))
        |-> cur_dat == $past(cur_dat) + PW'(1));

    // R8: interrupt only follows a completion while connected
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(cmd_done && linked) && !linked));

    // R10: disconnect while connected ends the link
    a_r10_disc_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && disc) |=> !linked);

    // R9: save or restore with nothing connected is flagged
    a_r9_idle_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (!linked && (save_dp || restore_all)) |=> xfer_ptr_keeper.err_proto);
endmodule

bind xfer_ptr_keeper xfer_ptr_keeper_chk #(.NT(NT), .PW(PW), .TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv_cmd     (adv_cmd),
    .adv_dat     (adv_dat),
    .save_dp     (save_dp),
    .restore_all (restore_all),
    .disc        (disc),
    .cmd_done    (cmd_done),
    .linked      (linked),
    .cur_cmd     (cur_cmd),
    .cur_dat     (cur_dat),
    .cur_sts     (cur_sts),
    .irq         (irq)
);

// File: tb/xfer_ptr_keeper_test.sv
`timescale 1ns/1ps
module xfer_ptr_keeper_test;
    localparam int NT = 4;
    localparam int PW = 32;
    localparam int TW = 2;

    logic clk = 0, rst_n = 0;
    logic open_vld = 0, adv_cmd = 0, adv_dat = 0, adv_sts = 0;
    logic save_dp = 0, restore_all = 0, disc = 0, reconn = 0, cmd_done = 0;
    logic [TW-1:0] open_tid = 0, reconn_tid = 0;
    logic [PW-1:0] open_cmd = 0, open_dat = 0, open_sts = 0;
    logic linked, irq, err_reopen, err_proto;
    logic [TW-1:0] link_tid, irq_tid;
    logic [PW-1:0] cur_cmd, cur_dat, cur_sts;

    int n_chk = 0, n_bad = 0;
    bit fin = 0;
    bit cmp_on = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    xfer_ptr_keeper #(.NT(NT), .PW(PW)) uut (.*);

    // behavioural reference
    logic [PW-1:0] m_sc[NT], m_sd[NT], m_ss[NT];
    bit m_act[NT];
    bit m_lnk, m_irq, m_er, m_ep;
    int m_tid, m_itid;
    logic [PW-1:0] m_c, m_d, m_s;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin m_act[i] = 0; m_sc[i] = 0; m_sd[i] = 0; m_ss[i] = 0; end
            m_lnk = 0; m_irq = 0; m_er = 0; m_ep = 0; m_tid = 0; m_itid = 0;
            m_c = 0; m_d = 0; m_s = 0;
        end else begin
            bit old_act[NT];
            logic [PW-1:0] o_sc[NT], o_sd[NT], o_ss[NT];
            for (int i = 0; i < NT; i++) begin
                old_act[i] = m_act[i]; o_sc[i] = m_sc[i]; o_sd[i] = m_sd[i]; o_ss[i] = m_ss[i];
            end
            m_irq = 0; m_er = 0; m_ep = 0;
            if (open_vld) begin
                if (old_act[open_tid]) m_er = 1;
                else begin
                    m_act[open_tid] = 1;
                    m_sc[open_tid] = open_cmd; m_sd[open_tid] = open_dat; m_ss[open_tid] = open_sts;
                end
            end
            if (!m_lnk) begin
                if (save_dp || restore_all) m_ep = 1;
                if (reconn) begin
                    if (old_act[reconn_tid]) begin
                        m_lnk = 1; m_tid = reconn_tid;
                        m_c = o_sc[reconn_tid]; m_d = o_sd[reconn_tid]; m_s = o_ss[reconn_tid];
                    end else m_ep = 1;
                end
            end else begin
                if (reconn) m_ep = 1;
                if (cmd_done) begin
                    m_irq = 1; m_itid = m_tid; m_act[m_tid] = 0;
                    m_lnk = 0; m_c = 0; m_d = 0; m_s = 0;
                end else if (disc) begin
                    m_lnk = 0; m_c = 0; m_d = 0; m_s = 0;
                end else if (restore_all) begin
                    m_c = o_sc[m_tid]; m_d = o_sd[m_tid]; m_s = o_ss[m_tid];
                end else begin
                    if (save_dp) m_sd[m_tid] = m_d;
                    if (adv_cmd) m_c = m_c + 1;
                    if (adv_dat) m_d = m_d + 1;
                    if (adv_sts) m_s = m_s + 1;
                end
            end
        end
    end

    task automatic chk(string fld, logic [PW-1:0] got, logic [PW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, fld, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("linked", PW'(linked), PW'(m_lnk));
            if (m_lnk) chk("link_tid", PW'(link_tid), PW'(m_tid));
            chk("cur_cmd", cur_cmd, m_c);
            chk("cur_dat", cur_dat, m_d);
            chk("cur_sts", cur_sts, m_s);
            chk("irq", PW'(irq), PW'(m_irq));
            if (m_irq) chk("irq_tid", PW'(irq_tid), PW'(m_itid));
            chk("err_reopen", PW'(err_reopen), PW'(m_er));
            chk("err_proto", PW'(err_proto), PW'(m_ep));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
        open_vld = 0; adv_cmd = 0; adv_dat = 0; adv_sts = 0; save_dp = 0;
        restore_all = 0; disc = 0; reconn = 0; cmd_done = 0;
    endtask

    task automatic do_open(int t, logic [PW-1:0] c, d, s);
        open_vld = 1; open_tid = TW'(t); open_cmd = c; open_dat = d; open_sts = s; cyc();
    endtask

    task automatic do_reconn(int t);
        reconn = 1; reconn_tid = TW'(t); cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1";
        chk("reset linked", PW'(linked), 0);
        chk("reset ptrs", cur_cmd | cur_dat | cur_sts, 0);
        chk("reset flags", PW'({irq, err_reopen, err_proto}), 0);
        @(posedge clk); #1 rst_n = 1;
        cmp_on = 1;
        cyc();

        tag = "R2";
        do_open(0, 32'h1000, 32'h2000, 32'h3000);
        do_open(1, 32'h100, 32'h200, 32'h300);
        do_open(2, 32'hA0, 32'hB0, 32'hC0);
        do_open(1, 32'h7, 32'h7, 32'h7);          // rejected reopen
        tag = "R9";
        save_dp = 1; cyc();
        restore_all = 1; cyc();
        tag = "R4";
        adv_cmd = 1; adv_dat = 1; cyc();          // idle strobes ignored
        tag = "R3";
        do_reconn(3);                              // inactive thread
        do_reconn(0);
        tag = "R4";
        repeat (3) begin adv_cmd = 1; cyc(); end
        repeat (5) begin adv_dat = 1; adv_sts = 1; cyc(); end
        tag = "R5";
        save_dp = 1; adv_dat = 1; cyc();
        repeat (4) begin adv_dat = 1; adv_cmd = 1; cyc(); end
        tag = "R6";
        restore_all = 1; save_dp = 1; adv_dat = 1; cyc();
        tag = "R3";
        do_reconn(1);                              // while held
        tag = "R7";
        adv_dat = 1; cyc();
        disc = 1; cyc();
        adv_cmd = 1; adv_dat = 1; adv_sts = 1; cyc();
        do_reconn(0);
        tag = "R10";
        disc = 1; cmd_done = 1; restore_all = 1; cyc();
        cmd_done = 1; disc = 1; cyc();             // idle: ignored
        tag = "R8";
        do_reconn(0);                              // closed thread
        do_open(0, 32'h5000, 32'h6000, 32'h7000);
        do_reconn(1);
        adv_sts = 1; cyc();
        cmd_done = 1; adv_sts = 1; cyc();
        cyc();

        tag = "R10";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 99);
            open_vld = (r < 8); open_tid = TW'($urandom_range(0, NT-1));
            open_cmd = $urandom; open_dat = $urandom; open_sts = $urandom;
            reconn = ($urandom_range(0, 9) == 0); reconn_tid = TW'($urandom_range(0, NT-1));
            adv_cmd = $urandom_range(0, 1); adv_dat = $urandom_range(0, 1); adv_sts = $urandom_range(0, 1);
            save_dp = ($urandom_range(0, 14) == 0); restore_all = ($urandom_range(0, 19) == 0);
            disc = ($urandom_range(0, 24) == 0); cmd_done = ($urandom_range(0, 29) == 0);
            cyc();
        end
        cyc(); cyc();
        fin = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule